// File: doc/BRIEF.md
# Dual Limit-Compare Interval Timer

This block holds two independent counter channels behind a small word-wide register bus. Each channel has a counter, a terminal value and a two-bit control field. While a channel's run bit is set and the halt input is low, the counter steps up by one every clock. When the counter equals the terminal value, it returns to zero on the next step. The period is therefore the terminal value plus one.

Each channel can raise a sticky interrupt on reaching its terminal value. The interrupt line stays high until software writes that channel's control register, and any value written clears it. To get one-shot behaviour, leave the interrupt alone after it fires. To get periodic behaviour, rewrite the control field with the interrupt-enable bit set from the service routine. Loading zero into the counter and all ones into the terminal value turns a channel into a free-running wrapping counter.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every counter, terminal value, control bit and pending flag is zero, both irq lines are low and every read returns zero.
- R2: addr[2] selects the channel, and addr[1:0] selects the register: 0 is the counter, 1 is control, 2 is the terminal value, and 3 reads zero and ignores writes. In control, bit 0 is interrupt enable, bit 1 is run, and bit 3 reads back the pending flag. All other control bits read zero.
- R3: A channel's counter increases by exactly one per clock while its run bit is 1 and halt_i is 0. Otherwise the counter holds its value.
- R4: When a running counter equals its terminal value, it becomes zero on the next clock. With a start of 0 and a terminal value of all ones, the channel counts through every value and wraps.
- R5: A terminal match with interrupt enable set makes the channel's irq go high on the next clock. The line stays high until a control write to that channel, which clears it whatever value is written.
- R6: If a control write and a terminal match occur in the same clock, the pending flag ends up cleared.
- R7: A counter write in the same clock as an increment loads the written value; the increment is lost.
- R8: The two channels do not affect each other's state or interrupt.
- R9: With a terminal value of zero, a running counter stays at zero and matches on every clock. If interrupt enable is kept set, the interrupt re-asserts one clock after each clear.
- R10: A match while interrupt enable is 0 leaves irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Core halted; stops both counters |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (channel in bit 2) |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data for addr, combinational |
| irq | output | 2 | Sticky interrupt per channel |

## Verification
The bench aims at a control write that lands in the same clock as a terminal match, using a zero terminal value so the two always coincide. A design that let the match win would keep irq high after the acknowledge. It also writes the counter while the counter is running; a design that gave the increment priority would read back one more than the value written. Further cases are halt toggling mid-count, where a faulty gate would keep stepping, and wrap at all ones. A dropped carry or a wrap taken one step late would show up as a wrong counter value on the clock-by-clock comparison.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt_i,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic [1:0]   irq
);
  localparam int NCH = 2;
  localparam logic [1:0] OFS_CNT = 2'd0;
  localparam logic [1:0] OFS_CTL = 2'd1;
  localparam logic [1:0] OFS_LIM = 2'd2;

  logic [W-1:0] rd_ch [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [W-1:0] cnt, lim;
    logic         ie, run_en, pend;
    logic         sel, run, hit;

    assign sel = wr_en && (addr[2] == 1'(g));
    assign run = run_en && !halt_i;
    assign hit = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt    <= '0;
        lim    <= '0;
        ie     <= 1'b0;
        run_en <= 1'b0;
        pend   <= 1'b0;
      end else begin
        if (sel && addr[1:0] == OFS_CNT) cnt <= wr_data;
        else if (hit)                    cnt <= '0;
        else if (run)                    cnt <= cnt + 1'b1;

        if (sel && addr[1:0] == OFS_LIM) lim <= wr_data;

        if (sel && addr[1:0] == OFS_CTL) begin
          ie     <= wr_data[0];
          run_en <= wr_data[1];
          pend   <= 1'b0;
        end else if (hit && ie) begin
          pend   <= 1'b1;
        end
      end
    end

    always_comb begin
      case (addr[1:0])
        OFS_CNT: rd_ch[g] = cnt;
        OFS_CTL: rd_ch[g] = {{(W-4){1'b0}}, pend, 1'b0, run_en, ie};
        OFS_LIM: rd_ch[g] = lim;
        default: rd_ch[g] = '0;
      endcase
    end

    assign irq[g] = pend;
  end

  assign rd_data = rd_ch[addr[2]];
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         halt_i,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic [1:0]   irq
);
  logic ctl0, ctl1;
  assign ctl0 = wr_en && addr == 3'd1;
  assign ctl1 = wr_en && addr == 3'd5;

  AST_CLEAR_CH0:      assert property (@(posedge clk) disable iff (!rst_n) ctl0 |=> !irq[0]); // R6
  AST_CLEAR_CH1:      assert property (@(posedge clk) disable iff (!rst_n) ctl1 |=> !irq[1]); // R5
  AST_FALL_BY_ACK0:   assert property (@(posedge clk) disable iff (!rst_n) $fell(irq[0]) |-> $past(ctl0)); // R5
  AST_FALL_BY_ACK1:   assert property (@(posedge clk) disable iff (!rst_n) $fell(irq[1]) |-> $past(ctl1)); // R8
  AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) (irq != 2'b00 && $past(irq) == 2'b00) |-> $past(!halt_i)); // R3
  AST_HALT_HOLDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (halt_i && !wr_en) |=> $stable(irq)); // R3
endmodule

bind dual_interval_timer dual_interval_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, halt_i = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] rd_data;
  logic [1:0] irq;
  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  dual_interval_timer #(.W(W)) u_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #2 clk = ~clk;

  logic [W-1:0] m_cnt [2];
  logic [W-1:0] m_lim [2];
  bit m_ie [2], m_run [2], m_pend [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        m_cnt[t] <= 0; m_lim[t] <= 0; m_ie[t] <= 0; m_run[t] <= 0; m_pend[t] <= 0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        automatic bit mine = wr_en && (addr[2] == t[0]);
        automatic bit going = m_run[t] && !halt_i;
        automatic bit at_end = going && (m_cnt[t] == m_lim[t]);
        if (mine && addr[1:0] == 0) m_cnt[t] <= wr_data;
        else if (going) m_cnt[t] <= at_end ? 0 : m_cnt[t] + 1;
        if (mine && addr[1:0] == 2) m_lim[t] <= wr_data;
        if (mine && addr[1:0] == 1) begin
          m_ie[t] <= wr_data[0]; m_run[t] <= wr_data[1]; m_pend[t] <= 0;
        end else if (at_end && m_ie[t]) m_pend[t] <= 1;
      end
    end
  end

  function automatic logic [W-1:0] exp_rd(logic [2:0] a);
    int t = a[2];
    case (a[1:0])
      0: return m_cnt[t];
      1: return W'({m_pend[t], 1'b0, m_run[t], m_ie[t]});
      2: return m_lim[t];
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    automatic logic [W-1:0] e = exp_rd(addr);
    automatic logic [1:0] ei = {m_pend[1], m_pend[0]};
    compared++;
    if (rd_data !== e || irq !== ei) begin
      mismatched++;
      $display("FAIL %s addr=%0d rd=%h exp=%h irq=%b exp=%b", cur_req, addr, rd_data, e, irq, ei);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wr_en = 1; addr = a; wr_data = d; tick(); wr_en = 0;
  endtask
  task automatic look(logic [2:0] a, int n);
    addr = a; tick(n);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      summary(); $finish;
    end
  end

  initial begin
    cur_req = "R1";
    tick(3);
    for (int a = 0; a < 8; a++) look(3'(a), 1);
    rst_n = 1; tick(); for (int a = 0; a < 8; a++) look(3'(a), 1);

    cur_req = "R2";
    wr(3'd2, 32'h1234_5678); wr(3'd0, 32'h0000_00AA); wr(3'd6, 32'hCAFE_0001);
    wr(3'd4, 32'h55); wr(3'd3, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFF0); wr(3'd1, 32'h0);
    for (int a = 0; a < 8; a++) look(3'(a), 1);

    cur_req = "R3";
    wr(3'd2, 100); wr(3'd0, 5); wr(3'd1, 2);
    look(3'd0, 10); halt_i = 1; look(3'd0, 5); halt_i = 0; look(3'd0, 4);
    wr(3'd1, 0); look(3'd0, 4);

    cur_req = "R4";
    wr(3'd2, 7); wr(3'd0, 0); wr(3'd1, 2); look(3'd0, 20); wr(3'd1, 0);
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFF0); wr(3'd5, 2); look(3'd4, 30);

    cur_req = "R5";
    wr(3'd2, 5); wr(3'd0, 0); wr(3'd1, 3); look(3'd1, 12);
    wr(3'd1, 3); look(3'd1, 8); wr(3'd1, 32'hF0); look(3'd1, 6);

    cur_req = "R10";
    wr(3'd2, 2); wr(3'd0, 0); wr(3'd1, 2); look(3'd1, 10);

    cur_req = "R9";
    wr(3'd2, 0); wr(3'd0, 0); wr(3'd1, 3); look(3'd0, 4);
    cur_req = "R6";
    wr(3'd1, 3); look(3'd1, 1); wr(3'd1, 3); wr(3'd1, 3); look(3'd1, 3);
    wr(3'd1, 0);

    cur_req = "R7";
    wr(3'd2, 1000); wr(3'd0, 0); wr(3'd1, 2); look(3'd0, 5);
    wr(3'd0, 50); look(3'd0, 3); wr(3'd0, 999); look(3'd0, 4);

    cur_req = "R8";
    wr(3'd6, 3); wr(3'd4, 0); wr(3'd5, 3); wr(3'd2, 9); wr(3'd0, 0); wr(3'd1, 3);
    look(3'd4, 6); look(3'd0, 6); wr(3'd5, 3); look(3'd1, 5);
    halt_i = 1; look(3'd5, 4); halt_i = 0; look(3'd4, 6);

    done = 1;
    summary();
    $finish;
  end
endmodule